// File: doc/BRIEF.md
# Call and Return Stack Sequencer

This block carries out the stack half of subroutine calls and returns for a small processor core. On a call it saves a 16-bit return address as two bytes in an internal byte-wide RAM, using an 8-bit stack pointer that grows upward, and then presents the branch target as the new program counter. On a return it reads the two saved bytes back into the program counter and lowers the stack pointer again.

A return-from-interrupt runs the same two-byte pop and also releases the in-service interrupt level. The block keeps a small set of in-service level bits, and the highest level that is set is the one released. The decoder that chooses the operation and the interrupt arbiter that raises a level are outside the block. They drive the request pins and the level-entry pins.

The RAM port is a simple single-port interface. It has a write enable, an address and write data. Read data comes back one clock after the address is presented. Each step of an operation uses one RAM access.

Top module: `call_ret_stack`

## Requirements
- R1: After reset, busy, done, ram_we and in_service are all 0, pc is 0000h and sp is 07h.
- R2: A call accepted with stack pointer S writes the low byte of ret_addr to address S+1, and in the next clock writes the high byte to address S+2. The stack pointer ends at S+2.
- R3: After a call, done is 1 in the third cycle after the request cycle, and pc then equals call_target. busy is 1 from the cycle after the request until done.
- R4: A return with stack pointer S loads pc with {mem[S], mem[S-1]}, taking the high byte from the upper address. The stack pointer ends at S-2, and done is 1 in the fourth cycle after the request cycle.
- R5: All stack pointer arithmetic wraps modulo 256. A call at FFh writes to 00h and 01h, and a return at 01h reads 01h and 00h.
- R6: done is high for exactly one cycle per operation. While busy is 1, call, return and load requests are ignored, so a completed call is not disturbed by a return request made during it. ram_we is 0 whenever busy is 0.
- R7: A return-from-interrupt with no in-service bit set gives the same pc, stack pointer and cycle count as a plain return, and in_service stays 0.
- R8: A return-from-interrupt clears only the highest-numbered set bit of in_service, and does so at the edge where done rises. For example, 11b becomes 01b, and 01b becomes 00b.
- R9: A pulse on isr_enter sets in_service bit isr_level. If it coincides with the completing edge of a return-from-interrupt, the clear is applied first and the set second. So 01b entering level 1 gives 10b, and 10b entering level 1 stays 10b.
- R10: When idle, requests are taken in this priority order: sp_load, then call_req, then ret_req, then reti_req. A sp_load sets sp to sp_din in the next cycle and starts no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_req | input | 1 | Start a call (push ret_addr, jump to call_target) |
| ret_req | input | 1 | Start a plain return |
| reti_req | input | 1 | Start a return-from-interrupt |
| ret_addr | input | 16 | Return address to save |
| call_target | input | 16 | Subroutine entry address |
| sp_load | input | 1 | Load the stack pointer when idle |
| sp_din | input | 8 | Value for sp_load |
| isr_enter | input | 1 | Mark an interrupt level as in service |
| isr_level | input | 1 | Level set by isr_enter |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after the address |
| sp | output | 8 | Stack pointer |
| pc | output | 16 | Program counter result |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, pc valid |
| in_service | output | 2 | In-service interrupt level bits |

## Verification
The case that needs care is a return-from-interrupt releasing a level in the same edge that the arbiter marks a new level as in service. The bench raises isr_enter exactly in the cycle before done of a return-from-interrupt. It does this once with the lower level active and a higher level entering, and once with the same level both released and re-entered. The resulting in_service is then compared with the clear-then-set result. A second overlap is a return request made while a call is still writing. The bench judges this by checking that the call's memory contents, stack pointer and pc are unchanged, and that no extra done pulse appears.

// File: rtl/call_ret_stack.sv
module call_ret_stack #(
  parameter int          AW     = 16,
  parameter int          LEVELS = 2,
  parameter logic [7:0]  SP_RST = 8'h07,
  localparam int         LW     = $clog2(LEVELS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_req,
  input  logic          ret_req,
  input  logic          reti_req,
  input  logic [AW-1:0] ret_addr,
  input  logic [AW-1:0] call_target,
  input  logic          sp_load,
  input  logic [7:0]    sp_din,
  input  logic          isr_enter,
  input  logic [LW-1:0] isr_level,
  output logic          ram_we,
  output logic [7:0]    ram_addr,
  output logic [7:0]    ram_wdata,
  input  logic [7:0]    ram_rdata,
  output logic [7:0]    sp,
  output logic [AW-1:0] pc,
  output logic          busy,
  output logic          done,
  output logic [LEVELS-1:0] in_service
);

  typedef enum logic [2:0] {S_IDLE, S_PUSH_LO, S_PUSH_HI, S_POP_HI, S_POP_LO, S_POP_END} state_t;

  state_t        state;
  logic [AW-1:0] ret_q, tgt_q;
  logic [7:0]    hi_q;
  logic          is_reti;
  logic [LEVELS-1:0] top_mask, set_mask, clr_mask;

  wire pushing = (state == S_PUSH_LO) || (state == S_PUSH_HI);

  assign busy      = (state != S_IDLE);
  assign ram_we    = pushing;
  assign ram_addr  = pushing ? sp + 8'd1 : sp;
  assign ram_wdata = (state == S_PUSH_LO) ? ret_q[7:0] : ret_q[15:8];

  always_comb begin
    top_mask = '0;
    for (int i = 0; i < LEVELS; i++)
      if (in_service[i]) top_mask = LEVELS'(1) << i;
  end

  assign set_mask = isr_enter ? (LEVELS'(1) << isr_level) : '0;
  assign clr_mask = (state == S_POP_END && is_reti) ? top_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) in_service <= '0;
    else        in_service <= (in_service & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      sp      <= SP_RST;
      pc      <= '0;
      ret_q   <= '0;
      tgt_q   <= '0;
      hi_q    <= '0;
      is_reti <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (sp_load) sp <= sp_din;
          else if (call_req) begin
            ret_q <= ret_addr;
            tgt_q <= call_target;
            state <= S_PUSH_LO;
          end else if (ret_req || reti_req) begin
            is_reti <= !ret_req;
            state   <= S_POP_HI;
          end
        end
        S_PUSH_LO: begin sp <= sp + 8'd1; state <= S_PUSH_HI; end
        S_PUSH_HI: begin sp <= sp + 8'd1; pc <= tgt_q; done <= 1'b1; state <= S_IDLE; end
        S_POP_HI:  begin sp <= sp - 8'd1; state <= S_POP_LO; end
        S_POP_LO:  begin hi_q <= ram_rdata; sp <= sp - 8'd1; state <= S_POP_END; end
        S_POP_END: begin pc <= {hi_q, ram_rdata}; done <= 1'b1; state <= S_IDLE; end
        default:   state <= S_IDLE;
      endcase
    end
  end

  AST_SP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> sp == $past(sp) + 8'd1); // R2
  AST_SP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POP_HI || state == S_POP_LO) |=> sp == $past(sp) - 8'd1); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ram_we); // R6
  AST_RELEASE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~in_service & $past(in_service))) |-> done); // R8
  AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~in_service & $past(in_service)) <= 1); // R8

endmodule

// File: tb/call_ret_stack_test.sv
module call_ret_stack_test;
  logic clk = 0, rst_n = 0;
  logic call_req = 0, ret_req = 0, reti_req = 0, sp_load = 0, isr_enter = 0;
  logic [15:0] ret_addr = 0, call_target = 0;
  logic [7:0] sp_din = 0;
  logic [0:0] isr_level = 0;
  logic ram_we, busy, done;
  logic [7:0] ram_addr, ram_wdata, sp;
  logic [7:0] ram_rdata = 0;
  logic [15:0] pc;
  logic [1:0] in_service;
  logic [7:0] mem [256];
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr];
  end

  call_ret_stack uut (.clk, .rst_n, .call_req, .ret_req, .reti_req, .ret_addr,
    .call_target, .sp_load, .sp_din, .isr_enter, .isr_level, .ram_we, .ram_addr,
    .ram_wdata, .ram_rdata, .sp, .pc, .busy, .done, .in_service);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 0 call, 1 ret, 2 reti; inj: cycle index at which isr_enter is driven
  task automatic op(input int kind, input logic [15:0] ra, input logic [15:0] tg,
                    input int inj, input logic lvl, output int cyc);
    ret_addr = ra; call_target = tg;
    call_req = (kind == 0); ret_req = (kind == 1); reti_req = (kind == 2);
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      call_req = 0; ret_req = 0; reti_req = 0;
      if (done || cyc > 20) break;
      isr_enter = (cyc == inj); isr_level = lvl;
    end
    isr_enter = 0;
    if (cyc > 20) chk(0, "watchdog", cyc, 0);
  endtask

  task automatic load_sp(input logic [7:0] v);
    sp_load = 1; sp_din = v;
    @(negedge clk); sp_load = 0;
    @(negedge clk);
  endtask

  task automatic enter(input logic lvl);
    isr_enter = 1; isr_level = lvl;
    @(negedge clk); isr_enter = 0;
  endtask

  int cyc;
  logic [15:0] ra, tg;
  logic [7:0] s1, s2;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !ram_we, "R1 ctrl", {busy, done, ram_we}, 0);
    chk(sp == 8'h07, "R1 sp", sp, 8'h07);
    chk(pc == 16'h0, "R1 pc", pc, 0);
    chk(in_service == 2'b00, "R1 in_service", in_service, 0);

    for (int s = 0; s < 256; s++) begin
      ra = 16'((s * 257) ^ 16'h1234);
      tg = 16'(s * 97 + 5);
      s1 = 8'(s + 1); s2 = 8'(s + 2);
      load_sp(8'(s));
      chk(sp == 8'(s), "R10 sp_load", sp, s);
      op(0, ra, tg, -1, 0, cyc);
      chk(cyc == 3, "R3 call latency", cyc, 3);
      chk(pc == tg, "R3 call pc", pc, tg);
      chk(mem[s1] == ra[7:0], s >= 254 ? "R5 low byte" : "R2 low byte", mem[s1], ra[7:0]);
      chk(mem[s2] == ra[15:8], s >= 254 ? "R5 high byte" : "R2 high byte", mem[s2], ra[15:8]);
      chk(sp == s2, "R2 sp after call", sp, s2);
      @(negedge clk);
      chk(!done && !busy, "R6 done pulse", done, 0);
      op(1, 0, 0, -1, 0, cyc);
      chk(cyc == 4, "R4 ret latency", cyc, 4);
      chk(pc == ra, s >= 254 ? "R5 ret pc" : "R4 ret pc", pc, ra);
      chk(sp == 8'(s), "R4 sp after ret", sp, s);
    end

    // R6: return request during a call is ignored
    load_sp(8'h40);
    ret_addr = 16'hA1B2; call_target = 16'h0C0D; call_req = 1;
    @(negedge clk); call_req = 0; ret_req = 1;
    @(negedge clk); ret_req = 0; sp_load = 1; sp_din = 8'h99;
    @(negedge clk); sp_load = 0;
    chk(done && pc == 16'h0C0D, "R6 call intact pc", pc, 16'h0C0D);
    chk(sp == 8'h42 && mem[8'h41] == 8'hB2 && mem[8'h42] == 8'hA1, "R6 call intact mem", sp, 8'h42);
    @(negedge clk);
    chk(!busy && !done, "R6 no extra op", {busy, done}, 0);

    // R10: call beats ret; load beats call
    ret_addr = 16'h5566; call_target = 16'h7788; call_req = 1; ret_req = 1;
    @(negedge clk); call_req = 0; ret_req = 0;
    @(negedge clk); @(negedge clk);
    chk(done && pc == 16'h7788 && sp == 8'h44, "R10 call priority", pc, 16'h7788);
    @(negedge clk);
    sp_load = 1; sp_din = 8'h10; call_req = 1;
    @(negedge clk); sp_load = 0; call_req = 0;
    chk(sp == 8'h10 && !busy, "R10 load priority", {busy, sp}, 8'h10);
    @(negedge clk);
    chk(!busy && !done, "R10 no op after load", busy, 0);

    // R7: reti with nothing in service
    op(0, 16'hBEEF, 16'h0300, -1, 0, cyc);
    op(2, 0, 0, -1, 0, cyc);
    chk(cyc == 4 && pc == 16'hBEEF, "R7 reti as ret pc", pc, 16'hBEEF);
    chk(sp == 8'h10 && in_service == 2'b00, "R7 reti state", {in_service, sp}, 8'h10);

    // R8, R9: level set and highest-first release
    enter(0);
    chk(in_service == 2'b01, "R9 set level0", in_service, 2'b01);
    enter(1);
    chk(in_service == 2'b11, "R9 set level1", in_service, 2'b11);
    op(0, 16'h1003, 16'h2000, -1, 0, cyc);
    op(0, 16'h0207, 16'h043A, -1, 0, cyc);
    chk(mem[8'h13] == 8'h07 && mem[8'h14] == 8'h02 && sp == 8'h14, "R2 nested push", mem[8'h13], 8'h07);
    op(2, 0, 0, -1, 0, cyc);
    chk(pc == 16'h0207 && in_service == 2'b01, "R8 release level1", in_service, 2'b01);
    op(2, 0, 0, -1, 0, cyc);
    chk(pc == 16'h1003 && in_service == 2'b00, "R8 release level0", in_service, 2'b00);

    // R9: release and entry in the same edge
    enter(0);
    op(0, 16'h3344, 16'h0001, -1, 0, cyc);
    op(2, 0, 0, 3, 1, cyc);
    chk(in_service == 2'b10, "R9 clear0 set1", in_service, 2'b10);
    chk(pc == 16'h3344, "R9 pc", pc, 16'h3344);
    op(0, 16'h5566, 16'h0002, -1, 0, cyc);
    op(2, 0, 0, 3, 1, cyc);
    chk(in_service == 2'b10, "R9 clear1 set1", in_service, 2'b10);
    op(1, 0, 0, -1, 0, cyc);
    @(negedge clk);
    chk(in_service == 2'b10, "R8 plain ret keeps level", in_service, 2'b10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule